// File: doc/BRIEF.md
# HyperBus Memory Transaction Sequencer

This block is the host side of an 8-bit double-data-rate memory link with a chip select, a bus clock, a bidirectional data strobe (RWDS) and an 8-bit data bus. A client hands it one transaction at a time through a valid/ready request port. Each request carries a direction, an address-space select, a burst-type select, a 32-bit word address and a 16-bit word count. The sequencer sends a 48-bit command/address word as six bytes and inserts an initial latency. It picks single or double latency from the level the memory drives on RWDS while the command/address phase is running. It then moves 16-bit words, each as a high byte followed by a low byte, and holds chip select high for a programmable recovery gap before it accepts the next request.

The bus moves one byte per system clock cycle. The bus clock output toggles once per system cycle while chip select is low, so every system cycle is one bus clock edge. The pad drivers sit outside the block, so each bidirectional line appears as a separate output value, output enable and input. Read bytes are taken on transitions of the incoming RWDS, not on a count of clock edges. A cycle in which RWDS does not change delivers no byte.

Top module: `hbseq_top`

## Requirements
- R1: A request is accepted on a clock edge where reqValid and reqReady are both high. From the next cycle, chip select is low for six cycles carrying command/address bits [47:40], [39:32], [31:24], [23:16], [15:8], [7:0] in that order on hbDqOut with hbDqOe high. The bus clock is high in the first of those cycles and toggles every cycle while chip select is low.
- R2: Command/address bit 47 is 1 for a read and 0 for a write. Bit 46 is 1 for register space and 0 for memory space. Bit 45 is 1 for a linear burst and 0 for a wrapped burst. Bits 44..16 carry reqAddr[31:3], bits 15..3 are zero, and bits 2..0 carry reqAddr[2:0].
- R3: The RWDS input level sampled at the end of the fourth command/address cycle selects the latency. If it is low, the latency phase lasts 2*tAcc cycles; if it is high, it lasts 4*tAcc cycles. During latency, chip select stays low, the clock keeps toggling and the host drives neither DQ nor RWDS.
- R4: A register-space write has no latency phase. Its data starts in the cycle right after the sixth command/address cycle, whatever level RWDS had.
- R5: A write sends each word as its high byte and then its low byte, one per cycle, with hbDqOe high. For memory space the host drives RWDS with the word's mask: wrMask[1] goes with the high byte, wrMask[0] with the low byte, and 1 means the byte is not written. For register space RWDS is not driven.
- R6: wrReady is high for one cycle before the first byte of each write word, and wrData/wrMask are taken on that clock edge.
- R7: During read data, the first RWDS transition after latency gives the high byte and the next one gives the low byte. Cycles with no RWDS transition are ignored. rdValid pulses for one cycle, in the cycle after the low byte, with rdData = {high byte, low byte}.
- R8: Outside the command/address and write-data cycles, hbDqOe and hbRwdsOe are low, so the host releases both lines from the end of the command/address phase through all read data.
- R9: After the last data cycle, chip select goes high and the clock stays low for max(tRwr,1) recovery cycles with busy high. Chip select therefore stays high for at least max(tRwr,1)+1 cycles between transactions.
- R10: reqReady is high only while busy is low. A request held valid during a transaction or its recovery is not accepted until busy falls. The bus clock is low whenever chip select is high.
- R11: After reset, chip select is high, the clock is low, both output enables are low, busy and rdValid are low, and reqReady is high.
- R12: A word count of 0 is handled as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bus edge per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqRegSpace | input | 1 | 1 = register space, 0 = memory space |
| reqLinear | input | 1 | 1 = linear burst, 0 = wrapped burst |
| reqAddr | input | 32 | Word address |
| reqLen | input | LEN_W | Number of 16-bit words (0 counts as 1) |
| tAcc | input | CNT_W | Initial latency count |
| tRwr | input | CNT_W | Recovery count in cycles |
| busy | output | 1 | High from acceptance until recovery ends |
| wrData | input | 16 | Write word |
| wrMask | input | 2 | Write byte mask, 1 = skip byte |
| wrReady | output | 1 | Write word taken on this edge |
| rdData | output | 16 | Read word |
| rdValid | output | 1 | rdData valid pulse |
| hbCsN | output | 1 | Chip select, active low |
| hbClk | output | 1 | Bus clock |
| hbDqOut | output | 8 | Data bus output value |
| hbDqOe | output | 1 | Data bus output enable |
| hbDqIn | input | 8 | Data bus input value |
| hbRwdsOut | output | 1 | RWDS output value (write mask) |
| hbRwdsOe | output | 1 | RWDS output enable |
| hbRwdsIn | input | 1 | RWDS input value |

## Verification
A wrong phase state or a miscounted latency counter moves chip select, the bus clock or the output enables off their expected cycle. The model compares those ports every cycle, so the fault shows within one cycle of the bad transition. A corrupted latched latency choice stretches or shrinks the latency phase and appears as a data byte or RWDS transition landing in the wrong cycle. A broken byte-capture phase or word counter shows up as a wrong rdData, or as a missing or extra rdValid pulse, on the next word. A bad recovery count shows as chip select falling too early or busy staying high too long.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;
  localparam int HB_ADDR_W = 32;
  localparam int HB_CA_W   = 48;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CA, ST_LAT, ST_WR, ST_RD, ST_REC
  } seqState_t;

  typedef struct packed {
    logic       takeReq;
    logic       sampleLat;
    logic       loadWord;
    logic       capA;
    logic       capB;
    logic       driveCa;
    logic       driveWr;
    logic       lowByte;
    logic [2:0] caSel;
  } seqStrobe_t;
endpackage

// File: rtl/hbseq_ctrl.sv
module hbseq_ctrl
  import hbseq_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CNT_W-1:0] tAcc,
  input  logic [CNT_W-1:0] tRwr,
  input  logic             isRead,
  input  logic             regSpace,
  input  logic             dblLat,
  input  logic             rwdsEdge,
  output logic             reqReady,
  output logic             busy,
  output logic             wrReady,
  output logic             hbCsN,
  output logic             hbClk,
  output seqStrobe_t       stb
);
  localparam int LAT_W = CNT_W + 2;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seqState_t        state, stateNx;
  logic [2:0]       caIdx;
  logic [LAT_W-1:0] latCnt, latEdges;
  logic [LEN_W-1:0] wordsLeft;
  logic [CNT_W-1:0] recCnt, accReg, rwrReg;
  logic             sub, clkPh, active, wrSkip;

  assign latEdges = dblLat ? {accReg, 2'b00} : {1'b0, accReg, 1'b0};
  assign active   = (state == ST_CA) || (state == ST_LAT) ||
                    (state == ST_WR) || (state == ST_RD);
  assign wrSkip   = !isRead && regSpace;

  always_comb begin
    stb         = '0;
    stb.caSel   = caIdx;
    stb.lowByte = sub;
    stateNx     = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.takeReq = 1'b1;
        stateNx     = ST_CA;
      end
      ST_CA: begin
        stb.driveCa = 1'b1;
        if (caIdx == 3'd3) stb.sampleLat = 1'b1;
        if (caIdx == 3'd5) begin
          if (wrSkip || latEdges == '0) begin
            stateNx      = isRead ? ST_RD : ST_WR;
            stb.loadWord = !isRead;
          end else begin
            stateNx = ST_LAT;
          end
        end
      end
      ST_LAT: if (latCnt == '0) begin
        stateNx      = isRead ? ST_RD : ST_WR;
        stb.loadWord = !isRead;
      end
      ST_WR: begin
        stb.driveWr = 1'b1;
        if (sub) begin
          if (wordsLeft > LEN_ONE) stb.loadWord = 1'b1;
          else                     stateNx = ST_REC;
        end
      end
      ST_RD: if (rwdsEdge) begin
        if (!sub) stb.capA = 1'b1;
        else begin
          stb.capB = 1'b1;
          if (wordsLeft == LEN_ONE) stateNx = ST_REC;
        end
      end
      ST_REC: if (recCnt <= CNT_ONE) stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign wrReady  = stb.loadWord;
  assign hbCsN    = !active;
  assign hbClk    = active && clkPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      caIdx     <= '0;
      latCnt    <= '0;
      wordsLeft <= '0;
      recCnt    <= '0;
      accReg    <= '0;
      rwrReg    <= '0;
      sub       <= 1'b0;
      clkPh     <= 1'b0;
    end else begin
      state <= stateNx;
      if (stb.takeReq)  clkPh <= 1'b1;
      else if (active)  clkPh <= ~clkPh;
      else              clkPh <= 1'b0;
      if (stb.takeReq) begin
        caIdx     <= '0;
        sub       <= 1'b0;
        wordsLeft <= (reqLen == '0) ? LEN_ONE : reqLen;
        accReg    <= tAcc;
        rwrReg    <= tRwr;
      end
      if (state == ST_CA) caIdx <= caIdx + 3'd1;
      if (state == ST_CA && caIdx == 3'd5) latCnt <= latEdges - LAT_ONE;
      else if (state == ST_LAT)            latCnt <= latCnt - LAT_ONE;
      if (state == ST_WR) begin
        sub <= ~sub;
        if (sub && wordsLeft > LEN_ONE) wordsLeft <= wordsLeft - LEN_ONE;
      end
      if (stb.capA) sub <= 1'b1;
      if (stb.capB) begin
        sub       <= 1'b0;
        wordsLeft <= wordsLeft - LEN_ONE;
      end
      if (state != ST_REC && stateNx == ST_REC) recCnt <= rwrReg;
      else if (state == ST_REC)                 recCnt <= recCnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/hbseq_dpath.sv
module hbseq_dpath
  import hbseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic                 reqRead,
  input  logic                 reqRegSpace,
  input  logic                 reqLinear,
  input  logic [HB_ADDR_W-1:0] reqAddr,
  input  logic [15:0]          wrData,
  input  logic [1:0]           wrMask,
  input  logic [7:0]           hbDqIn,
  input  logic                 hbRwdsIn,
  output logic [7:0]           hbDqOut,
  output logic                 hbDqOe,
  output logic                 hbRwdsOut,
  output logic                 hbRwdsOe,
  output logic [15:0]          rdData,
  output logic                 rdValid,
  output logic                 isRead,
  output logic                 regSpace,
  output logic                 dblLat,
  output logic                 rwdsEdge
);
  logic [HB_CA_W-1:0] caWord;
  logic [15:0]        wordReg;
  logic [1:0]         maskReg;
  logic [7:0]         byteA, caByte, wrByte;
  logic               rwdsPrev;

  assign isRead   = caWord[47];
  assign regSpace = caWord[46];
  assign rwdsEdge = hbRwdsIn ^ rwdsPrev;

  always_comb begin
    case (stb.caSel)
      3'd0:    caByte = caWord[47:40];
      3'd1:    caByte = caWord[39:32];
      3'd2:    caByte = caWord[31:24];
      3'd3:    caByte = caWord[23:16];
      3'd4:    caByte = caWord[15:8];
      default: caByte = caWord[7:0];
    endcase
  end

  assign wrByte    = stb.lowByte ? wordReg[7:0] : wordReg[15:8];
  assign hbDqOe    = stb.driveCa || stb.driveWr;
  assign hbDqOut   = stb.driveCa ? caByte : (stb.driveWr ? wrByte : 8'h00);
  assign hbRwdsOe  = stb.driveWr && !regSpace;
  assign hbRwdsOut = hbRwdsOe && (stb.lowByte ? maskReg[0] : maskReg[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      caWord   <= '0;
      wordReg  <= '0;
      maskReg  <= '0;
      byteA    <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      dblLat   <= 1'b0;
      rwdsPrev <= 1'b0;
    end else begin
      rwdsPrev <= hbRwdsIn;
      rdValid  <= stb.capB;
      if (stb.takeReq)
        caWord <= {reqRead, reqRegSpace, reqLinear, reqAddr[31:3], 13'd0, reqAddr[2:0]};
      if (stb.sampleLat) dblLat <= hbRwdsIn;
      if (stb.loadWord) begin
        wordReg <= wrData;
        maskReg <= wrMask;
      end
      if (stb.capA) byteA  <= hbDqIn;
      if (stb.capB) rdData <= {byteA, hbDqIn};
    end
  end
endmodule

// File: rtl/hbseq_top.sv
module hbseq_top
  import hbseq_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqRead,
  input  logic             reqRegSpace,
  input  logic             reqLinear,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CNT_W-1:0] tAcc,
  input  logic [CNT_W-1:0] tRwr,
  output logic             busy,
  input  logic [15:0]      wrData,
  input  logic [1:0]       wrMask,
  output logic             wrReady,
  output logic [15:0]      rdData,
  output logic             rdValid,
  output logic             hbCsN,
  output logic             hbClk,
  output logic [7:0]       hbDqOut,
  output logic             hbDqOe,
  input  logic [7:0]       hbDqIn,
  output logic             hbRwdsOut,
  output logic             hbRwdsOe,
  input  logic             hbRwdsIn
);
  seqStrobe_t stb;
  logic       isRead, regSpace, dblLat, rwdsEdge;

  hbseq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .tAcc(tAcc), .tRwr(tRwr), .isRead(isRead), .regSpace(regSpace),
    .dblLat(dblLat), .rwdsEdge(rwdsEdge), .reqReady(reqReady), .busy(busy),
    .wrReady(wrReady), .hbCsN(hbCsN), .hbClk(hbClk), .stb(stb)
  );

  hbseq_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqRead(reqRead),
    .reqRegSpace(reqRegSpace), .reqLinear(reqLinear), .reqAddr(reqAddr),
    .wrData(wrData), .wrMask(wrMask), .hbDqIn(hbDqIn), .hbRwdsIn(hbRwdsIn),
    .hbDqOut(hbDqOut), .hbDqOe(hbDqOe), .hbRwdsOut(hbRwdsOut),
    .hbRwdsOe(hbRwdsOe), .rdData(rdData), .rdValid(rdValid),
    .isRead(isRead), .regSpace(regSpace), .dblLat(dblLat), .rwdsEdge(rwdsEdge)
  );
endmodule

// File: rtl/hbseq_chk.sv
module hbseq_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic busy,
  input logic hbCsN,
  input logic hbClk,
  input logic hbDqOe,
  input logic hbRwdsOe,
  input logic rdValid
);
  // R10
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hbCsN |-> !hbClk);

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hbCsN |-> (!hbDqOe && !hbRwdsOe));

  // R1
  accept_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !hbCsN);

  // R9
  rec_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbCsN) |-> busy);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbCsN) |=> hbCsN);

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
endmodule

bind hbseq_top hbseq_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busy(busy), .hbCsN(hbCsN), .hbClk(hbClk), .hbDqOe(hbDqOe),
  .hbRwdsOe(hbRwdsOe), .rdValid(rdValid)
);

// File: tb/hbseq_top_tb_top.sv
module hbseq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqRead = 1'b0, reqRegSpace = 1'b0, reqLinear = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic [7:0]  tAcc = '0, tRwr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  wrMask = '0;
  logic [7:0]  hbDqIn = '0;
  logic        hbRwdsIn = 1'b0;
  logic        reqReady, busy, wrReady, rdValid, hbCsN, hbClk, hbDqOe, hbRwdsOut, hbRwdsOe;
  logic [15:0] rdData;
  logic [7:0]  hbDqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbseq_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqRegSpace(reqRegSpace), .reqLinear(reqLinear),
    .reqAddr(reqAddr), .reqLen(reqLen), .tAcc(tAcc), .tRwr(tRwr), .busy(busy),
    .wrData(wrData), .wrMask(wrMask), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .hbCsN(hbCsN), .hbClk(hbClk), .hbDqOut(hbDqOut),
    .hbDqOe(hbDqOe), .hbDqIn(hbDqIn), .hbRwdsOut(hbRwdsOut),
    .hbRwdsOe(hbRwdsOe), .hbRwdsIn(hbRwdsIn)
  );

  typedef struct {
    bit cs; bit ck; bit doe; bit [7:0] dq; bit roe; bit ro;
    bit wr; bit bz; bit rv; bit [15:0] rd; bit inR; bit [7:0] inD; int ph;
  } cyc_t;

  cyc_t        expQ[$];
  bit [15:0]   wWords[$];
  bit [1:0]    wMasks[$];
  bit [15:0]   rWords[$];
  int          errors = 0, checks = 0;
  int          gIdx = 0;
  bit          pendRv = 0;
  bit [15:0]   pendRd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(int ph);
    case (ph)
      0: return "R1";
      1: return "R3";
      2: return "R5";
      3: return "R7";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic newCyc(input int ph, input bit act, output cyc_t c);
    c = '{default: 0};
    c.ph = ph;
    c.cs = !act;
    c.bz = 1;
    if (act) begin
      c.ck = (gIdx % 2 == 0);
      gIdx++;
    end
  endtask

  task automatic pushCyc(input cyc_t c);
    cyc_t t = c;
    t.rv = pendRv;
    t.rd = pendRd;
    pendRv = 0;
    expQ.push_back(t);
  endtask

  // Behavioural per-cycle model of one transaction.
  task automatic buildTxn(input bit rd, input bit rg, input bit lin, input bit [31:0] addr,
                          input int n, input int acc, input int rwr, input bit latHi,
                          input bit stall, output int lat);
    bit [47:0] ca = {rd, rg, lin, addr[31:3], 13'd0, addr[2:0]};
    cyc_t c;
    gIdx = 0;
    pendRv = 0;
    lat = (!rd && rg) ? 0 : acc * (latHi ? 4 : 2);
    for (int k = 0; k < 6; k++) begin
      newCyc(0, 1, c);
      c.doe = 1;
      c.dq  = ca[47 - 8*k -: 8];
      c.inR = latHi;
      c.wr  = (k == 5) && !rd && (lat == 0);
      pushCyc(c);
    end
    for (int j = 0; j < lat; j++) begin
      newCyc(1, 1, c);
      c.wr = !rd && (j == lat - 1);
      pushCyc(c);
    end
    if (!rd) begin
      for (int w = 0; w < n; w++) begin
        newCyc(2, 1, c);
        c.doe = 1; c.dq = wWords[w][15:8]; c.roe = !rg; c.ro = !rg && wMasks[w][1];
        pushCyc(c);
        newCyc(2, 1, c);
        c.doe = 1; c.dq = wWords[w][7:0]; c.roe = !rg; c.ro = !rg && wMasks[w][0];
        c.wr = (w < n - 1);
        pushCyc(c);
      end
    end else begin
      for (int w = 0; w < n; w++) begin
        newCyc(3, 1, c);
        c.inR = 1; c.inD = rWords[w][15:8];
        pushCyc(c);
        if (stall && (w % 2 == 0)) begin
          newCyc(3, 1, c);
          c.inR = 1; c.inD = 8'h5A;
          pushCyc(c);
        end
        newCyc(3, 1, c);
        c.inR = 0; c.inD = rWords[w][7:0];
        pushCyc(c);
        pendRv = 1;
        pendRd = rWords[w];
      end
    end
    for (int r = 0; r < ((rwr == 0) ? 1 : rwr); r++) begin
      newCyc(4, 0, c);
      pushCyc(c);
    end
    newCyc(5, 0, c);
    c.bz = 0;
    pushCyc(c);
  endtask

  // Entered right after a negedge with the design idle; returns at the idle negedge.
  task automatic runTxn(input bit rd, input bit rg, input bit lin, input bit [31:0] addr,
                        input int len, input int acc, input int rwr, input bit latHi,
                        input bit stall, input bit holdValid);
    int n = (len == 0) ? 1 : len;
    int lat, actCnt = 0, rvCnt = 0, hiRun = 0, wIdx = 0;
    bit prevWr = 0;
    cyc_t e;
    string tg;
    buildTxn(rd, rg, lin, addr, n, acc, rwr, latHi, stall, lat);
    reqRead = rd; reqRegSpace = rg; reqLinear = lin; reqAddr = addr;
    reqLen = 16'(len); tAcc = 8'(acc); tRwr = 8'(rwr); reqValid = 1;
    wrData = (wWords.size() > 0) ? wWords[0] : '0;
    wrMask = (wMasks.size() > 0) ? wMasks[0] : '0;
    chk(reqReady == 1'b1 && busy == 1'b0, "R10", "ready before accept", {reqReady, busy}, 2'b10);
    @(posedge clk);
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      @(negedge clk);
      if (!holdValid) reqValid = 0;
      if (prevWr) wIdx++;
      wrData = (wIdx < wWords.size()) ? wWords[wIdx] : '0;
      wrMask = (wIdx < wMasks.size()) ? wMasks[wIdx] : '0;
      hbRwdsIn = e.inR;
      hbDqIn   = e.inD;
      tg = tagOf(e.ph);
      chk(hbCsN == e.cs, tg, "csN", hbCsN, e.cs);
      chk(hbClk == e.ck, tg, "bus clock", hbClk, e.ck);
      chk(hbDqOe == e.doe, (e.ph == 1 || e.ph == 3) ? "R8" : tg, "dq enable", hbDqOe, e.doe);
      chk(hbRwdsOe == e.roe, (e.ph == 1 || e.ph == 3) ? "R8" : tg, "rwds enable", hbRwdsOe, e.roe);
      if (e.doe) chk(hbDqOut == e.dq, (e.ph == 0) ? "R1 R2" : tg, "dq byte", hbDqOut, e.dq);
      if (e.roe) chk(hbRwdsOut == e.ro, "R5", "rwds mask", hbRwdsOut, e.ro);
      chk(wrReady == e.wr, "R6", "wrReady", wrReady, e.wr);
      chk(busy == e.bz, "R10", "busy", busy, e.bz);
      chk(rdValid == e.rv, "R7", "rdValid", rdValid, e.rv);
      if (e.rv) chk(rdData == e.rd, "R7", "rdData", rdData, e.rd);
      if (!hbCsN) begin actCnt++; hiRun = 0; end
      else hiRun++;
      if (rdValid) rvCnt++;
      prevWr = e.wr;
    end
    chk(actCnt == 6 + lat + 2*n + ((rd && stall) ? (n + 1)/2 : 0),
        (!rd && rg) ? "R4" : "R3", "cycles with chip select low", actCnt,
        6 + lat + 2*n + ((rd && stall) ? (n + 1)/2 : 0));
    chk(rvCnt == (rd ? n : 0), (len == 0) ? "R12" : "R7", "read word count", rvCnt, rd ? n : 0);
    chk(hiRun == ((rwr == 0) ? 1 : rwr) + 1, "R9", "csN high run", hiRun, ((rwr == 0) ? 1 : rwr) + 1);
    hbRwdsIn = 0;
    wWords.delete(); wMasks.delete(); rWords.delete();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(hbCsN && !hbClk && !hbDqOe && !hbRwdsOe && !busy && !rdValid, "R11",
        "state in reset", {hbCsN, hbClk, hbDqOe, hbRwdsOe, busy, rdValid}, 6'b100000);
    rstN = 1;
    @(negedge clk);
    @(negedge clk);
    // R11 after release
    chk(hbCsN && !hbClk && !hbDqOe && !hbRwdsOe && !busy && !rdValid && reqReady, "R11",
        "state after reset", {hbCsN, hbClk, hbDqOe, hbRwdsOe, busy, rdValid, reqReady}, 7'b1000001);

    // Memory write, single latency, masks, held request during busy (R10)
    wWords = '{16'hA1B2, 16'hC3D4}; wMasks = '{2'b00, 2'b10};
    runTxn(0, 0, 1, 32'h1234_5675, 2, 3, 4, 0, 0, 1);
    // Memory read, double latency, RWDS stall cycles, wrapped burst
    rWords = '{16'h1357, 16'h2468, 16'h9ABC};
    runTxn(1, 0, 0, 32'hFEDC_BA98, 3, 2, 2, 1, 1, 0);
    // Register write: no latency even with RWDS high (R4), zero recovery
    wWords = '{16'h8F01}; wMasks = '{2'b11};
    runTxn(0, 1, 1, 32'h0000_0003, 1, 5, 0, 1, 0, 0);
    // Register read with zero word count (R12)
    rWords = '{16'h55AA};
    runTxn(1, 1, 0, 32'h8000_0001, 0, 1, 1, 0, 0, 0);
    // Memory read, single latency, back-to-back words
    rWords = '{16'h0F0F, 16'hF00F};
    runTxn(1, 0, 1, 32'h0003_FFFF, 2, 4, 3, 0, 0, 0);
    // Memory write, double latency, three words
    wWords = '{16'h1111, 16'h2222, 16'h3333}; wMasks = '{2'b01, 2'b00, 2'b11};
    runTxn(0, 0, 0, 32'h7654_3210, 3, 1, 1, 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule